// File: doc/BRIEF.md
# Interrupt Acknowledge Unit with Software-Interrupt Source Tracking

This block serves a processor's interrupt-acknowledge read and keeps the per-source state of the sixteen software-generated interrupts (IDs 0 to 15). For every processor and every software interrupt it holds an 8-bit map that records which processors have requested that interrupt. It also holds a pending flag, an active flag and one running priority per processor.

A send request names an interrupt ID, a target mask and a sending processor. Register writes can set bits in one map or clear bits from it. An acknowledge strobe carries the processor, the interrupt ID chosen by an external priority selector and that interrupt's priority. The block answers with a 32-bit acknowledge word. For a software interrupt, the number of the requesting processor sits in bits [12:10] of that word.

The pending, active and running-priority state is exported so the external selector can choose the next candidate. A read port returns any one source map.

Top module: `sgi_ack_unit`

## Requirements
- R1: After reset every source map, pending flag and active flag is zero, each running priority is 256 (idle, one above the lowest 8-bit priority), and the acknowledge word is 1023.
- R2: A send request sets, for each processor whose bit is set in the target mask, that processor's pending flag for the ID and bit `sender` of its source map.
- R3: A set-type register write ORs the 8-bit data into the addressed map and sets that pending flag, even when the data is zero.
- R4: A clear-type register write removes the data bits from the addressed map and clears the pending flag only when the map ends up empty; a non-empty map keeps the flag set.
- R5: An accepted acknowledge of a software interrupt picks the lowest set bit k of the map, clears only bit k, and returns `ID | (k << 10)`. An empty map gives k = 0.
- R6: The pending flag of a software interrupt stays set while its map is non-empty and is cleared by the acknowledge that takes the last source.
- R7: An accepted acknowledge loads the processor's running priority with the presented priority and sets the active flag for a software ID. An ID of 16 or more is returned unchanged and leaves all software-interrupt state alone.
- R8: An acknowledge whose priority is numerically greater than or equal to the processor's running priority returns 1023 and changes no state.
- R9: An acknowledge that presents an ID from 1020 to 1023 (nothing pending) returns 1023 and changes no state.
- R10: Bits [31:13] of the acknowledge word are always zero, and the word holds its value between acknowledges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| send_vld | input | 1 | Send request strobe |
| send_id | input | 4 | Software interrupt ID to send |
| send_src | input | CPU_W | Sending processor |
| send_targets | input | NUM_CPU | Target processor mask |
| wr_vld | input | 1 | Register write strobe |
| wr_set | input | 1 | 1 = set-type write, 0 = clear-type write |
| wr_cpu | input | CPU_W | Processor whose map is written |
| wr_id | input | 4 | Software interrupt ID written |
| wr_data | input | 8 | Source bits to set or clear |
| ack_vld | input | 1 | Acknowledge strobe |
| ack_cpu | input | CPU_W | Acknowledging processor |
| ack_id | input | 10 | Candidate ID from the selector (1020 to 1023 = none) |
| ack_prio | input | PRIO_W | Priority of the candidate |
| ack_data_o | output | 32 | Acknowledge word, registered |
| pend_o | output | NUM_CPU*16 | Pending flags, index cpu*16+id |
| active_o | output | NUM_CPU*16 | Active flags, index cpu*16+id |
| run_prio_o | output | NUM_CPU*(PRIO_W+1) | Running priority per processor |
| rd_cpu | input | CPU_W | Map read: processor |
| rd_id | input | 4 | Map read: software interrupt ID |
| rd_src_o | output | 8 | Map read data |

## Verification
The assertions assume that at most one of send, register write and acknowledge arrives in a cycle. Under that assumption a pending flag set by one source cannot be cleared in the same edge by another. The stimulus issues one operation per strobe and returns every strobe to zero before the next one.

The assertions also assume the processor indices stay below NUM_CPU. The bench sweeps senders 0 to 3 on a four-processor build and writes map bits 4 to 7 only through the register path. Acknowledges come only from the bench's own pick of the lowest pending ID, or from IDs chosen on purpose to be refused, so every accepted acknowledge refers to a real candidate.

// File: rtl/sgi_ack_pkg.sv
package sgi_ack_pkg;
  localparam int SGI_NUM   = 16;
  localparam int SGI_ID_W  = 4;
  localparam int SRC_W     = 8;
  localparam int SRC_IDX_W = 3;
  localparam int INTID_W   = 10;
  localparam int ACK_W     = 32;
  localparam int SRC_SHIFT = 10;
  localparam logic [INTID_W-1:0] NO_INTID  = 10'd1023;
  localparam logic [INTID_W-1:0] SPUR_BASE = 10'd1020;

  function automatic logic [SRC_IDX_W-1:0] first_src(input logic [SRC_W-1:0] bm);
    logic [SRC_IDX_W-1:0] r;
    r = '0;
    for (int i = SRC_W - 1; i >= 0; i--) begin
      if (bm[i]) r = SRC_IDX_W'(i);
    end
    return r;
  endfunction

  function automatic logic id_is_sgi(input logic [INTID_W-1:0] id);
    return id < INTID_W'(SGI_NUM);
  endfunction

  function automatic logic id_is_none(input logic [INTID_W-1:0] id);
    return id >= SPUR_BASE;
  endfunction

  function automatic logic [ACK_W-1:0] ack_value(input logic [INTID_W-1:0] id,
                                                 input logic [SRC_IDX_W-1:0] src,
                                                 input logic sgi);
    logic [ACK_W-1:0] v;
    v = ACK_W'(id);
    if (sgi) v[SRC_SHIFT +: SRC_IDX_W] = src;
    return v;
  endfunction
endpackage

// File: rtl/sgi_src_cell.sv
module sgi_src_cell
  import sgi_ack_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SRC_W-1:0]     set_bits,
  input  logic                 set_pend,
  input  logic [SRC_W-1:0]     clr_bits,
  input  logic                 clr_req,
  input  logic                 take,
  output logic [SRC_W-1:0]     src_o,
  output logic                 pend_o,
  output logic                 act_o,
  output logic [SRC_IDX_W-1:0] low_o
);
  logic [SRC_W-1:0] src_q;
  logic             pend_q;
  logic             act_q;
  logic [SRC_W-1:0] take_mask;
  logic [SRC_W-1:0] src_nxt;
  logic             empties;

  assign low_o     = first_src(src_q);
  assign take_mask = take ? ((SRC_W'(1) << low_o) & src_q) : '0;
  assign src_nxt   = (src_q & ~clr_bits & ~take_mask) | set_bits;
  assign empties   = (clr_req | take) && (src_nxt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      pend_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      src_q <= src_nxt;
      if (set_pend)     pend_q <= 1'b1;
      else if (empties) pend_q <= 1'b0;
      if (take)         act_q  <= 1'b1;
    end
  end

  assign src_o  = src_q;
  assign pend_o = pend_q;
  assign act_o  = act_q;
endmodule

// File: rtl/sgi_ack_cpu.sv
module sgi_ack_cpu
  import sgi_ack_pkg::*;
#(
  parameter int PRIO_W = 8,
  localparam int RUN_W = PRIO_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel,
  input  logic [INTID_W-1:0] ack_id,
  input  logic [PRIO_W-1:0]  ack_prio,
  output logic               accept_o,
  output logic [RUN_W-1:0]   run_o
);
  localparam logic [RUN_W-1:0] RUN_IDLE = RUN_W'(1) << PRIO_W;

  function automatic logic prio_beats(input logic [PRIO_W-1:0] p, input logic [RUN_W-1:0] r);
    return {1'b0, p} < r;
  endfunction

  logic [RUN_W-1:0] run_q;

  assign accept_o = sel && !id_is_none(ack_id) && prio_beats(ack_prio, run_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_q <= RUN_IDLE;
    else if (accept_o) run_q <= {1'b0, ack_prio};
  end

  assign run_o = run_q;
endmodule

// File: rtl/sgi_ack_unit.sv
module sgi_ack_unit
  import sgi_ack_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int PRIO_W  = 8,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int RUN_W  = PRIO_W + 1,
  localparam int CELLS  = NUM_CPU * SGI_NUM
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     send_vld,
  input  logic [SGI_ID_W-1:0]      send_id,
  input  logic [CPU_W-1:0]         send_src,
  input  logic [NUM_CPU-1:0]       send_targets,
  input  logic                     wr_vld,
  input  logic                     wr_set,
  input  logic [CPU_W-1:0]         wr_cpu,
  input  logic [SGI_ID_W-1:0]      wr_id,
  input  logic [SRC_W-1:0]         wr_data,
  input  logic                     ack_vld,
  input  logic [CPU_W-1:0]         ack_cpu,
  input  logic [INTID_W-1:0]       ack_id,
  input  logic [PRIO_W-1:0]        ack_prio,
  output logic [ACK_W-1:0]         ack_data_o,
  output logic [CELLS-1:0]         pend_o,
  output logic [CELLS-1:0]         active_o,
  output logic [NUM_CPU*RUN_W-1:0] run_prio_o,
  input  logic [CPU_W-1:0]         rd_cpu,
  input  logic [SGI_ID_W-1:0]      rd_id,
  output logic [SRC_W-1:0]         rd_src_o
);
  logic [SRC_W-1:0]     src_all [CELLS];
  logic [SRC_IDX_W-1:0] low_all [CELLS];
  logic [NUM_CPU-1:0]   acc_w;
  logic [CELLS-1:0]     src_nz_w;
  logic                 acc_any_w;
  logic [SRC_IDX_W-1:0] low_sel_w;
  logic [ACK_W-1:0]     ack_q;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    sgi_ack_cpu #(.PRIO_W(PRIO_W)) u_cpu (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (ack_vld && (ack_cpu == CPU_W'(c))),
      .ack_id   (ack_id),
      .ack_prio (ack_prio),
      .accept_o (acc_w[c]),
      .run_o    (run_prio_o[c*RUN_W +: RUN_W])
    );

    for (genvar s = 0; s < SGI_NUM; s++) begin : g_sgi
      logic send_hit, wset_hit, wclr_hit;
      logic [SRC_W-1:0] set_bits, clr_bits;

      assign send_hit = send_vld && send_targets[c] && (send_id == SGI_ID_W'(s));
      assign wset_hit = wr_vld && wr_set && (wr_cpu == CPU_W'(c)) && (wr_id == SGI_ID_W'(s));
      assign wclr_hit = wr_vld && !wr_set && (wr_cpu == CPU_W'(c)) && (wr_id == SGI_ID_W'(s));
      assign set_bits = (send_hit ? (SRC_W'(1) << send_src) : '0) | (wset_hit ? wr_data : '0);
      assign clr_bits = wclr_hit ? wr_data : '0;

      sgi_src_cell u_cell (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_bits (set_bits),
        .set_pend (send_hit | wset_hit),
        .clr_bits (clr_bits),
        .clr_req  (wclr_hit),
        .take     (acc_w[c] && (ack_id == INTID_W'(s))),
        .src_o    (src_all[c*SGI_NUM+s]),
        .pend_o   (pend_o[c*SGI_NUM+s]),
        .act_o    (active_o[c*SGI_NUM+s]),
        .low_o    (low_all[c*SGI_NUM+s])
      );

      assign src_nz_w[c*SGI_NUM+s] = |src_all[c*SGI_NUM+s];
    end
  end

  assign acc_any_w = |acc_w;

  always_comb begin
    low_sel_w = '0;
    rd_src_o  = '0;
    for (int c = 0; c < NUM_CPU; c++) begin
      for (int s = 0; s < SGI_NUM; s++) begin
        if (ack_cpu == CPU_W'(c) && ack_id[SGI_ID_W-1:0] == SGI_ID_W'(s))
          low_sel_w = low_all[c*SGI_NUM+s];
        if (rd_cpu == CPU_W'(c) && rd_id == SGI_ID_W'(s))
          rd_src_o = src_all[c*SGI_NUM+s];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= ACK_W'(NO_INTID);
    else if (ack_vld)
      ack_q <= acc_any_w ? ack_value(ack_id, low_sel_w, id_is_sgi(ack_id)) : ACK_W'(NO_INTID);
  end

  assign ack_data_o = ack_q;
endmodule

// File: rtl/sgi_ack_unit_chk.sv
module sgi_ack_unit_chk
  import sgi_ack_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int PRIO_W  = 8,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int RUN_W  = PRIO_W + 1,
  localparam int CELLS  = NUM_CPU * SGI_NUM
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     send_vld,
  input logic [SGI_ID_W-1:0]      send_id,
  input logic [NUM_CPU-1:0]       send_targets,
  input logic                     ack_vld,
  input logic [CPU_W-1:0]         ack_cpu,
  input logic [INTID_W-1:0]       ack_id,
  input logic [PRIO_W-1:0]        ack_prio,
  input logic [ACK_W-1:0]         ack_data_o,
  input logic [CELLS-1:0]         pend_o,
  input logic [NUM_CPU*RUN_W-1:0] run_prio_o,
  input logic [NUM_CPU-1:0]       acc_w,
  input logic [CELLS-1:0]         src_nz_w
);
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ack_data_o[ACK_W-1:13] == '0); // R10

  AST_ONE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(acc_w)); // R7

  AST_NONE_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld && (ack_id >= SPUR_BASE) |=> ack_data_o == ACK_W'(NO_INTID)); // R9

  AST_LOW_PRIO_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld && (ack_id < SPUR_BASE) && ({1'b0, ack_prio} >= run_prio_o[ack_cpu*RUN_W +: RUN_W])
    |=> ack_data_o == ACK_W'(NO_INTID)); // R8

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    AST_RUN_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      acc_w[c] |=> run_prio_o[c*RUN_W +: RUN_W] == {1'b0, $past(ack_prio)}); // R7

    for (genvar s = 0; s < SGI_NUM; s++) begin : g_sgi
      AST_SRC_KEEPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        src_nz_w[c*SGI_NUM+s] |-> pend_o[c*SGI_NUM+s]); // R6

      AST_SEND_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        send_vld && send_targets[c] && (send_id == SGI_ID_W'(s)) |=> pend_o[c*SGI_NUM+s]); // R2
    end
  end
endmodule

bind sgi_ack_unit sgi_ack_unit_chk #(.NUM_CPU(NUM_CPU), .PRIO_W(PRIO_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .send_vld     (send_vld),
  .send_id      (send_id),
  .send_targets (send_targets),
  .ack_vld      (ack_vld),
  .ack_cpu      (ack_cpu),
  .ack_id       (ack_id),
  .ack_prio     (ack_prio),
  .ack_data_o   (ack_data_o),
  .pend_o       (pend_o),
  .run_prio_o   (run_prio_o),
  .acc_w        (acc_w),
  .src_nz_w     (src_nz_w)
);

// File: tb/sgi_ack_unit_bench.sv
module sgi_ack_unit_bench;
  localparam int NC = 4;
  localparam int PW = 8;
  localparam int RW = PW + 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst_n = 1'b0;
  logic            send_vld = 1'b0;
  logic [3:0]      send_id = '0;
  logic [1:0]      send_src = '0;
  logic [NC-1:0]   send_targets = '0;
  logic            wr_vld = 1'b0;
  logic            wr_set = 1'b0;
  logic [1:0]      wr_cpu = '0;
  logic [3:0]      wr_id = '0;
  logic [7:0]      wr_data = '0;
  logic            ack_vld = 1'b0;
  logic [1:0]      ack_cpu = '0;
  logic [9:0]      ack_id = '0;
  logic [PW-1:0]   ack_prio = '0;
  logic [31:0]     ack_data_o;
  logic [NC*16-1:0] pend_o;
  logic [NC*16-1:0] active_o;
  logic [NC*RW-1:0] run_prio_o;
  logic [1:0]      rd_cpu = '0;
  logic [3:0]      rd_id = '0;
  logic [7:0]      rd_src_o;

  sgi_ack_unit #(.NUM_CPU(NC), .PRIO_W(PW)) u_sgi_ack_unit (
    .clk(clk), .rst_n(rst_n),
    .send_vld(send_vld), .send_id(send_id), .send_src(send_src), .send_targets(send_targets),
    .wr_vld(wr_vld), .wr_set(wr_set), .wr_cpu(wr_cpu), .wr_id(wr_id), .wr_data(wr_data),
    .ack_vld(ack_vld), .ack_cpu(ack_cpu), .ack_id(ack_id), .ack_prio(ack_prio),
    .ack_data_o(ack_data_o), .pend_o(pend_o), .active_o(active_o), .run_prio_o(run_prio_o),
    .rd_cpu(rd_cpu), .rd_id(rd_id), .rd_src_o(rd_src_o)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0]  m_src  [NC][16];
  bit          m_pend [NC][16];
  bit          m_act  [NC][16];
  int          m_run  [NC];
  logic [31:0] m_ack;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_ports(input string req);
    logic [63:0] ep, ea;
    logic [NC*RW-1:0] er;
    ep = '0; ea = '0; er = '0;
    for (int c = 0; c < NC; c++) begin
      er[c*RW +: RW] = RW'(m_run[c]);
      for (int s = 0; s < 16; s++) begin
        ep[c*16+s] = m_pend[c][s];
        ea[c*16+s] = m_act[c][s];
      end
    end
    check(pend_o === ep[NC*16-1:0], req, "pending", 64'(pend_o), ep);
    check(active_o === ea[NC*16-1:0], req, "active", 64'(active_o), ea);
    check(run_prio_o === er, req, "running priority", 64'(run_prio_o), 64'(er));
    check(ack_data_o === m_ack, req, "ack word", 64'(ack_data_o), 64'(m_ack));
  endtask

  task automatic scan_src(input string req);
    for (int c = 0; c < NC; c++) begin
      for (int s = 0; s < 16; s++) begin
        @(negedge clk);
        rd_cpu = 2'(c);
        rd_id  = 4'(s);
        #2;
        check(rd_src_o === m_src[c][s], req, "source map", 64'(rd_src_o), 64'(m_src[c][s]));
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int c = 0; c < NC; c++) begin
      m_run[c] = 256;
      for (int s = 0; s < 16; s++) begin
        m_src[c][s] = '0; m_pend[c][s] = 1'b0; m_act[c][s] = 1'b0;
      end
    end
    m_ack = 32'd1023;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_ports("R1");
  endtask

  task automatic send(input int id, input logic [NC-1:0] tgt, input int src);
    @(negedge clk);
    send_vld = 1'b1; send_id = 4'(id); send_targets = tgt; send_src = 2'(src);
    @(negedge clk);
    send_vld = 1'b0;
    for (int c = 0; c < NC; c++) begin
      if (tgt[c]) begin
        m_src[c][id][src] = 1'b1;
        m_pend[c][id] = 1'b1;
      end
    end
    chk_ports("R2");
  endtask

  task automatic wr(input bit set, input int c, input int id, input logic [7:0] v);
    @(negedge clk);
    wr_vld = 1'b1; wr_set = set; wr_cpu = 2'(c); wr_id = 4'(id); wr_data = v;
    @(negedge clk);
    wr_vld = 1'b0;
    if (set) begin
      m_src[c][id] = m_src[c][id] | v;
      m_pend[c][id] = 1'b1;
      chk_ports("R3");
    end else begin
      m_src[c][id] = m_src[c][id] & ~v;
      if (m_src[c][id] == 8'h00) m_pend[c][id] = 1'b0;
      chk_ports("R4");
    end
  endtask

  task automatic ack(input int c, input int id, input int prio, input string req);
    @(negedge clk);
    ack_vld = 1'b1; ack_cpu = 2'(c); ack_id = 10'(id); ack_prio = PW'(prio);
    @(negedge clk);
    ack_vld = 1'b0;
    if (id >= 1020 || prio >= m_run[c]) begin
      m_ack = 32'd1023;
    end else begin
      m_run[c] = prio;
      if (id < 16) begin
        int k = 0;
        while (k < 8 && !m_src[c][id][k]) k++;
        if (k == 8) k = 0;
        m_src[c][id][k] = 1'b0;
        if (m_src[c][id] == 8'h00) m_pend[c][id] = 1'b0;
        m_act[c][id] = 1'b1;
        m_ack = 32'(id + k * 1024);
      end else begin
        m_ack = 32'(id);
      end
    end
    chk_ports(req);
  endtask

  task automatic drain(input int c);
    int prio = 250;
    ack(c, 1023, 0, "R9");
    forever begin
      int pick = -1;
      for (int s = 15; s >= 0; s--) if (m_pend[c][s]) pick = s;
      if (pick < 0) break;
      if (m_run[c] <= 255) ack(c, pick, m_run[c], "R8");
      ack(c, pick, prio, "R5 R6 R7");
      prio--;
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    scan_src("R1");

    for (int id = 0; id < 16; id++)
      for (int src = 0; src < NC; src++)
        send(id, NC'(((id * 5 + src) % 15) + 1), src);
    scan_src("R2");

    for (int c = 0; c < NC; c++) drain(c);
    scan_src("R6");

    ack(1, 40, 100, "R7");
    ack(1, 40, 100, "R8");
    ack(1, 1021, 10, "R9");
    check(ack_data_o[31:13] === 19'h0, "R10", "upper bits", 64'(ack_data_o[31:13]), 64'h0);

    do_reset();
    for (int s = 0; s < 16; s++)
      wr(1'b1, 2, s, (s == 5) ? 8'h00 : 8'((s * 29 + 3) & 8'hFF));
    scan_src("R3");
    for (int s = 0; s < 16; s++)
      wr(1'b0, 2, s, 8'((s * 13) & 8'hFF));
    scan_src("R4");
    wr(1'b1, 3, 9, 8'hF0);
    drain(2);
    drain(3);
    scan_src("R5");
    repeat (3) @(negedge clk);
    chk_ports("R10");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule